// File: doc/BRIEF.md
# DMA Interrupt Status Controller

This block collects the interrupt sources of one DMA channel into a single interrupt output. One source reports a finished block of work. Five sources report errors: a failed response while fetching a descriptor, a failed data read, a failed data write, a malformed descriptor, and a failed write of a completion event. Each source sets a sticky bit in a status word. Software clears a status bit by writing a one to a separate clear offset. A second word enables the bits, one by one, and the cause that takes part in interrupting is the status ANDed with the enable.

The cause is delivered in one of two ways, picked by a four-bit mode field. In wired mode a level line stays high for as long as any enabled cause is set. In message mode the block emits a single-cycle pulse, together with the cause vector, each time the enabled cause goes from empty to non-empty. A source that is still active sets its bit again straight after a clear, so the interrupt keeps firing until the condition behind it has gone away.

The register port is a plain word interface. A write is qualified by an enable and takes an offset. A read is combinational from a separate offset. Decoding of any wider bus is left to the surrounding logic.

Top module: `dma_irq_status_ctrl`

## Requirements
- R1: After reset the status, enable and mode words all read zero, and `irqLine` and `msgValid` are low.
- R2: Each implemented source (bit 0 end of block, bit 1 event write response error, bit 9 descriptor read response error, bit 10 data read error, bit 11 data write error, bit 14 malformed descriptor) that is high at a clock edge sets its status bit at that edge. The bit stays set until it is cleared. Source inputs at any other bit position are ignored, and those status bits always read 0. Status reads at offset 0x100.
- R3: A write to offset 0x108 clears every status bit whose data bit is 1 and leaves bits written with 0 untouched. Offset 0x108 reads as zero.
- R4: When a source is high in the same cycle that a clear hits its bit, the bit stays set. A source held high across a clear therefore keeps its bit set.
- R5: Offset 0x110 is the enable word. Only the six implemented bit positions can be written and read back; all other bits read 0. Writing all ones reads back 0x4E03.
- R6: The cause is status AND enable. A set status bit whose enable is 0 produces no interrupt of either kind.
- R7: When the mode is not 1, `msgValid` goes high for exactly one cycle on the cycle after the cause goes from zero to non-zero, and `msgCause` carries the cause in that cycle. While the cause stays non-zero, no further pulse follows.
- R8: Offset 0x004 holds the mode in bits 3:0 and reads it back with the upper bits zero. The value 1 selects wired delivery, and every other value selects message delivery.
- R9: In wired mode `irqLine` is high exactly while the cause is non-zero, and `msgValid` stays low. In message mode `irqLine` stays low.
- R10: Writes to any offset other than 0x004, 0x108 and 0x110 change nothing, and reads from any offset other than 0x004, 0x100 and 0x110 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 12 | Register write offset |
| wrData | input | 32 | Register write data |
| rdAddr | input | 12 | Register read offset |
| rdData | output | 32 | Register read data (combinational) |
| srcRaw | input | 16 | Interrupt source inputs, one per status bit position |
| irqLine | output | 1 | Level interrupt in wired mode |
| msgValid | output | 1 | Single-cycle message pulse in message mode |
| msgCause | output | 16 | Cause vector while `msgValid` is high, else zero |

## Verification
The hardest case to reach from the ports is a set and a clear landing on the same bit in the same cycle. The same applies to a source held high across several cycles while a clear is written. The stimulus drives the source and the clear write in one cycle on purpose, and then reads the status back. A second awkward case is a cause that becomes non-zero only because the enable is written, with no new source event. The bench reaches it by latching a source while its enable is 0 and enabling it later. After the directed sequences, a pseudo-random phase mixes sources, writes to all offsets (unused ones included) and mode changes. A behavioural model is compared with the outputs every cycle throughout.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  // Fixed bit positions of the interrupt sources.
  localparam int EOB_BIT      = 0;
  localparam int EVWR_BIT     = 1;
  localparam int DESC_RD_BIT  = 9;
  localparam int DATA_RD_BIT  = 10;
  localparam int DATA_WR_BIT  = 11;
  localparam int BAD_DESC_BIT = 14;

  // Register offsets.
  localparam int OFS_MODE = 'h004;
  localparam int OFS_STAT = 'h100;
  localparam int OFS_CLR  = 'h108;
  localparam int OFS_EN   = 'h110;

  localparam int MODE_WIRED = 1;

  localparam logic [31:0] SRC_MASK = (32'd1 << EOB_BIT) | (32'd1 << EVWR_BIT) |
                                     (32'd1 << DESC_RD_BIT) | (32'd1 << DATA_RD_BIT) |
                                     (32'd1 << DATA_WR_BIT) | (32'd1 << BAD_DESC_BIT);

  // Strobes from control to datapath.
  typedef struct packed {
    logic applyClear;
    logic loadEnable;
  } dpStrobe_t;

endpackage

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int STAT_W = 16,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [STAT_W-1:0] wrBits,
  input  logic [STAT_W-1:0] srcRaw,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [MODE_W-1:0] modeVal,
  output logic [STAT_W-1:0] cause,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [STAT_W-1:0] IMPL = STAT_W'(SRC_MASK);

  logic [STAT_W-1:0] statusQ;
  logic [STAT_W-1:0] enableQ;

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (IMPL[b]) begin : g_live
      logic stBit;
      logic enBit;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stBit <= 1'b0;
          enBit <= 1'b0;
        end else begin
          // set has priority over clear
          stBit <= (stBit & ~(strb.applyClear & wrBits[b])) | srcRaw[b];
          if (strb.loadEnable) enBit <= wrBits[b];
        end
      end
      assign statusQ[b] = stBit;
      assign enableQ[b] = enBit;
    end else begin : g_dead
      logic unusedIn;
      assign unusedIn   = srcRaw[b] ^ wrBits[b];
      assign statusQ[b] = 1'b0;
      assign enableQ[b] = 1'b0;
    end
  end

  assign cause = statusQ & enableQ;

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(OFS_STAT))      rdData = DATA_W'(statusQ);
    else if (rdAddr == ADDR_W'(OFS_EN))   rdData = DATA_W'(enableQ);
    else if (rdAddr == ADDR_W'(OFS_MODE)) rdData = DATA_W'(modeVal);
  end

  logic [STAT_W-1:0] srcHit;
  logic [STAT_W-1:0] clrBits;
  assign srcHit  = srcRaw & IMPL;
  assign clrBits = wrBits & IMPL;

  // R2
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.applyClear |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcHit != '0) |=> ((statusQ & $past(srcHit)) == $past(srcHit)));

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.applyClear && srcHit == '0) |=> ((statusQ & $past(clrBits)) == '0));

  // R5
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadEnable |=> $stable(enableQ));

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int STAT_W = 16,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [MODE_W-1:0] modeWrData,
  input  logic [STAT_W-1:0] cause,
  output dpStrobe_t         strb,
  output logic [MODE_W-1:0] modeVal,
  output logic              irqLine,
  output logic              msgValid,
  output logic [STAT_W-1:0] msgCause
);

  logic [MODE_W-1:0] modeQ;
  logic              prevNz;
  logic              causeNz;
  logic              wired;
  logic              modeWr;

  assign modeWr          = wrEn && (wrAddr == ADDR_W'(OFS_MODE));
  assign strb.applyClear = wrEn && (wrAddr == ADDR_W'(OFS_CLR));
  assign strb.loadEnable = wrEn && (wrAddr == ADDR_W'(OFS_EN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0;
      prevNz <= 1'b0;
    end else begin
      if (modeWr) modeQ <= modeWrData;
      prevNz <= causeNz;
    end
  end

  assign causeNz  = |cause;
  assign wired    = (modeQ == MODE_W'(MODE_WIRED));
  assign modeVal  = modeQ;
  assign irqLine  = wired & causeNz;
  assign msgValid = ~wired & causeNz & ~prevNz;
  assign msgCause = msgValid ? cause : '0;

  // R7
  msg_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |=> !msgValid);

  // R7
  msg_carries_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgCause != '0));

  // R9
  wired_no_msg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_W'(MODE_WIRED)) |-> !msgValid);

  // R9
  outputs_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(irqLine && msgValid));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeWr |=> $stable(modeQ));

endmodule

// File: rtl/dma_irq_status_ctrl.sv
module dma_irq_status_ctrl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int STAT_W = 16,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [STAT_W-1:0] srcRaw,
  output logic              irqLine,
  output logic              msgValid,
  output logic [STAT_W-1:0] msgCause
);

  dpStrobe_t         strb;
  logic [STAT_W-1:0] cause;
  logic [MODE_W-1:0] modeVal;
  logic              unusedWrHi;

  assign unusedWrHi = ^wrData[DATA_W-1:STAT_W];

  dma_irq_ctrl #(
    .ADDR_W(ADDR_W), .STAT_W(STAT_W), .MODE_W(MODE_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .modeWrData(wrData[MODE_W-1:0]), .cause(cause), .strb(strb),
    .modeVal(modeVal), .irqLine(irqLine), .msgValid(msgValid),
    .msgCause(msgCause)
  );

  dma_irq_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W), .MODE_W(MODE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrBits(wrData[STAT_W-1:0]),
    .srcRaw(srcRaw), .rdAddr(rdAddr), .modeVal(modeVal), .cause(cause),
    .rdData(rdData)
  );

endmodule

// File: tb/dma_irq_status_ctrl_tb.sv
module dma_irq_status_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IMPL = 16'h4E03;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [11:0] rdAddr = '0;
  logic [31:0] rdData;
  logic [15:0] srcRaw = '0;
  logic        irqLine;
  logic        msgValid;
  logic [15:0] msgCause;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_status_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .srcRaw(srcRaw), .irqLine(irqLine),
    .msgValid(msgValid), .msgCause(msgCause)
  );

  // Behavioural reference model
  logic [15:0] mSt, mEn;
  logic [3:0]  mMode;
  bit          mPrev;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mEn = 0; mMode = 0; mPrev = 0;
    end else begin
      mPrev = ((mSt & mEn) != 0);
      if (wrEn && wrAddr == 12'h108) mSt = mSt & ~wrData[15:0];
      mSt = mSt | (srcRaw & IMPL);
      if (wrEn && wrAddr == 12'h110) mEn = wrData[15:0] & IMPL;
      if (wrEn && wrAddr == 12'h004) mMode = wrData[3:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [15:0] c;
      logic [31:0] r;
      bit w;
      bit m;
      c = mSt & mEn;
      w = (mMode == 4'd1);
      m = !w && (c != 0) && !mPrev;
      chk("R6/R9 irqLine", {31'b0, irqLine}, {31'b0, w && (c != 0)});
      chk("R7 msgValid", {31'b0, msgValid}, {31'b0, m});
      chk("R7 msgCause", {16'b0, msgCause}, {16'b0, m ? c : 16'h0});
      case (rdAddr)
        12'h100: begin r = {16'b0, mSt}; chk("R2 status read", rdData, r); end
        12'h110: begin r = {16'b0, mEn}; chk("R5 enable read", rdData, r); end
        12'h004: begin r = {28'b0, mMode}; chk("R8 mode read", rdData, r); end
        12'h108: chk("R3 clear read", rdData, 32'h0);
        default: chk("R10 other read", rdData, 32'h0);
      endcase
    end
  end

  task automatic drive(input bit w, input logic [11:0] a, input logic [31:0] d,
                       input logic [15:0] s);
    @(posedge clk); #1;
    wrEn = w; wrAddr = a; wrData = d; srcRaw = s;
  endtask

  task automatic settle();
    drive(0, 12'h0, 32'h0, 16'h0);
    @(negedge clk);
  endtask

  task automatic readReg(input logic [11:0] a, output logic [31:0] v);
    rdAddr = a; #1; v = rdData;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irqLine", {31'b0, irqLine}, 0);
    chk("R1 msgValid", {31'b0, msgValid}, 0);
    readReg(12'h100, v); chk("R1 status", v, 0);
    readReg(12'h110, v); chk("R1 enable", v, 0);
    readReg(12'h004, v); chk("R1 mode", v, 0);

    drive(1, 12'h110, 32'hFFFF_FFFF, 0); settle();
    readReg(12'h110, v); chk("R5 enable mask", v, 32'h4E03);

    drive(0, 0, 0, 16'h0001); settle();
    chk("R7 pulse", {31'b0, msgValid}, 1);
    chk("R7 cause", {16'b0, msgCause}, 32'h0001);
    settle();
    chk("R7 single", {31'b0, msgValid}, 0);

    drive(0, 0, 0, 16'h0200); settle();
    chk("R7 no repeat", {31'b0, msgValid}, 0);
    readReg(12'h100, v); chk("R2 sticky", v, 32'h0201);

    drive(0, 0, 0, 16'h0008); settle();
    readReg(12'h100, v); chk("R2 unimplemented src", v, 32'h0201);

    drive(1, 12'h108, 32'h0001, 0); settle();
    readReg(12'h100, v); chk("R3 w1c", v, 32'h0200);
    readReg(12'h108, v); chk("R3 clear reads zero", v, 0);

    drive(1, 12'h108, 32'h0600, 16'h0400); settle();
    readReg(12'h100, v); chk("R4 set wins", v, 32'h0400);

    drive(0, 0, 0, 16'h0800);
    drive(1, 12'h108, 32'h0800, 16'h0800);
    drive(0, 0, 0, 16'h0800); settle();
    readReg(12'h100, v); chk("R4 held source", v, 32'h0C00);

    drive(1, 12'h108, 32'hFFFF, 0); settle();
    readReg(12'h100, v); chk("R3 clear all", v, 0);

    drive(1, 12'h004, 32'h1, 0); settle();
    readReg(12'h004, v); chk("R8 mode wired", v, 1);
    drive(0, 0, 0, 16'h4000); settle();
    chk("R9 wired line", {31'b0, irqLine}, 1);
    chk("R9 wired no msg", {31'b0, msgValid}, 0);
    drive(1, 12'h108, 32'h4000, 0); settle();
    chk("R9 line drops", {31'b0, irqLine}, 0);

    drive(1, 12'h004, 32'h5, 0); settle();
    readReg(12'h004, v); chk("R8 mode 5", v, 5);
    drive(0, 0, 0, 16'h0002); settle();
    chk("R8 mode 5 is message", {31'b0, msgValid}, 1);
    chk("R9 no line in message", {31'b0, irqLine}, 0);
    drive(1, 12'h108, 32'hFFFF, 0);

    drive(1, 12'h110, 32'h0, 0);
    drive(0, 0, 0, 16'h0001); settle();
    chk("R6 gated msg", {31'b0, msgValid}, 0);
    readReg(12'h100, v); chk("R6 status still set", v, 1);
    drive(1, 12'h110, 32'h1, 0); settle();
    chk("R7 pulse on enable", {31'b0, msgValid}, 1);

    drive(1, 12'h200, 32'hFFFF_FFFF, 0); settle();
    readReg(12'h200, v); chk("R10 other read", v, 0);
    readReg(12'h100, v); chk("R10 status untouched", v, 1);
    readReg(12'h110, v); chk("R10 enable untouched", v, 1);

    drive(1, 12'h004, 32'hFFFF_FFF1, 0); settle();
    readReg(12'h004, v); chk("R8 mode low nibble", v, 1);

    // Pseudo-random phase, checked by the per-cycle model
    lfsr = 32'h1D2C_3B4A;
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [11:0] ra;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[3:1])
        3'd0: a = 12'h004;
        3'd1, 3'd2: a = 12'h108;
        3'd3: a = 12'h110;
        3'd4: a = 12'h200;
        default: a = 12'h100;
      endcase
      case (lfsr[6:4])
        3'd0: ra = 12'h004;
        3'd1: ra = 12'h108;
        3'd2: ra = 12'h110;
        3'd3: ra = 12'h00C;
        default: ra = 12'h100;
      endcase
      drive(lfsr[7] & lfsr[9], a,
            (a == 12'h004) ? {28'h0, 2'b00, lfsr[11:10]} : {lfsr[15:0], lfsr[31:16]},
            lfsr[8] ? (lfsr[31:16] & lfsr[27:12]) : 16'h0);
      rdAddr = ra;
    end
    settle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule